// File: doc/BRIEF.md
# Dual-Style Host Bus Front End

This block sits between a host processor bus and the register files of a two-channel serial controller. It turns raw bus pins into clean, single-cycle register read and write pulses for one channel at a time, together with a register address and write data. A mode input decides how the pins are read. In separate-strobe style there is an active-low read strobe, an active-low write strobe and one active-low chip select per channel. In direction-line style there is one active-low chip select, the write-strobe pin becomes a read/write direction line, and the second chip-select pin becomes a fourth address bit that picks the channel.

Every bus pin passes through a synchronizer into the internal clock before any edge is looked for. Address and data travel through a synchronizer of the same depth, so they stay aligned with the strobes. A read pulse is issued once, when a read cycle begins, and the read data bus is driven for as long as that read cycle lasts. A write pulse is issued once, when the write cycle ends, and carries the last address and data seen during the cycle. The block also shapes the interrupt pins. In separate-strobe style each channel has its own interrupt pin, enabled by that channel's interrupt-enable control bit. In direction-line style there is a single open-drain, active-low request for the whole device.

Top module: `dsbus_front`

## Requirements
- R1: After reset no register read or write pulse is issued and the read data bus is not driven.
- R2: In separate-strobe style (`style_sep`=1) a read strobe held low with exactly one chip select low gives exactly one `reg_rd` pulse for that channel. `reg_addr` equals the bus address during the pulse, `rdata_out` carries that channel's register data and `data_oe` is high while the strobe stays low.
- R3: In separate-strobe style a write strobe low period gives exactly one `reg_wr` pulse, issued after the strobe is released. It carries the address and data present while the strobe was low, even if the bus data changes after the release.
- R4: In separate-strobe style `cs0_n` low selects channel 0 (bit 0 of the pulse vectors) and `cs1_n` low selects channel 1. With both selects low, or with both strobes low, no pulse is issued and the bus is not driven.
- R5: In direction-line style (`style_sep`=0) `rd_n` has no effect. With `cs0_n` low, `wr_n`=1 is a read (one `reg_rd` pulse at the start) and `wr_n`=0 is a write (one `reg_wr` pulse when `cs0_n` rises).
- R6: In direction-line style `cs1_n` acts as a channel address bit: 0 selects channel 0 and 1 selects channel 1.
- R7: `data_oe` is never high during a write cycle, and `rdata_out` shows the register data of the selected channel.
- R8: At most one pulse among `reg_rd` and `reg_wr` is high in any cycle, and a read pulse never lasts two cycles in a row.
- R9: In separate-strobe style, for each channel: `irq_oe` equals that channel's `irq_en`, `irq_out` equals its `irq_pend`, and `op2_n` is the inverse of `irq_en`.
- R10: In direction-line style, `irq_oe[0]` is high when either channel has an interrupt pending, and `irq_out[0]` is then 0 (open drain, active low). `irq_oe[1]` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| style_sep | input | 1 | 1: separate-strobe style, 0: direction-line style |
| rd_n | input | 1 | Read strobe (separate-strobe style only) |
| wr_n | input | 1 | Write strobe, or read(1)/write(0) direction line |
| cs0_n | input | 1 | Channel 0 select, or device select |
| cs1_n | input | 1 | Channel 1 select, or channel address bit |
| addr | input | ADDR_W | Register address |
| bus_din | input | DATA_W | Data from the host bus |
| rdata_out | output | DATA_W | Read data toward the host bus |
| data_oe | output | 1 | Read data bus drive enable |
| reg_rd | output | 2 | Per-channel register read pulse |
| reg_wr | output | 2 | Per-channel register write pulse |
| reg_addr | output | ADDR_W | Register address for the pulses |
| reg_wdata | output | DATA_W | Write data for the pulses |
| reg_rdata0 | input | DATA_W | Channel 0 register read data |
| reg_rdata1 | input | DATA_W | Channel 1 register read data |
| irq_pend | input | 2 | Per-channel pending interrupt |
| irq_en | input | 2 | Per-channel interrupt-enable control bit |
| irq_out | output | 2 | Interrupt pin levels |
| irq_oe | output | 2 | Interrupt pin drive enables |
| op2_n | output | 2 | Per-channel active-low auxiliary output |

## Verification
Register writes and reads are run in both bus styles, on both channels, with distinct addresses and data. This shows whether the channel decode, the address field and the data alignment are right. Strobes held low for several cycles, and data changed right after a strobe is released, show whether the pulses come exactly once and whether the write payload is captured at the right moment. Some patterns are illegal in one style: both selects low, or the read strobe low in direction-line style. These show that the pins are reinterpreted rather than merged. The interrupt pins are tried with every combination of pending and enable bits in both styles, which tells per-channel tri-state gating apart from shared open-drain signalling.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic rd_act;
    logic wr_act;
    logic ch;
  } cyc_req_t;

  // Interpret the synchronized pins according to the bus style.
  function automatic cyc_req_t decode_cycle(input logic sep, input logic rd_n,
                                            input logic wr_n, input logic cs0_n,
                                            input logic cs1_n);
    cyc_req_t r;
    logic one_sel;
    if (sep) begin
      one_sel  = cs0_n ^ cs1_n;
      r.ch     = cs0_n;
      r.rd_act = one_sel & ~rd_n & wr_n;
      r.wr_act = one_sel & ~wr_n & rd_n;
    end else begin
      r.ch     = cs1_n;
      r.rd_act = ~cs0_n & wr_n;
      r.wr_act = ~cs0_n & ~wr_n;
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] ch_onehot(input logic ch);
    return ch ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[0] <= RST_VAL;
          else        st[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= RST_VAL;
          else        st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/hbi_cycle.sv
module hbi_cycle
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_req_t          req,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_data,
  output logic [NCH-1:0]    reg_rd,
  output logic [NCH-1:0]    reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rd_live,
  output logic              rd_start,
  output logic              wr_end
);
  logic              prev_rd, prev_wr, cap_ch;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic              active;

  assign active = req.rd_act | req.wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd  <= 1'b0;
      prev_wr  <= 1'b0;
      cap_ch   <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      prev_rd <= req.rd_act;
      prev_wr <= req.wr_act;
      if (active) begin
        cap_ch   <= req.ch;
        cap_addr <= s_addr;
        cap_data <= s_data;
      end
    end
  end

  // a read needs a fresh cycle: not straight after a write phase
  assign rd_start  = req.rd_act & ~prev_rd & ~prev_wr;
  assign wr_end    = prev_wr & ~req.wr_act;
  assign rd_live   = req.rd_act;
  assign reg_rd    = rd_start ? ch_onehot(req.ch) : '0;
  assign reg_wr    = wr_end ? ch_onehot(cap_ch) : '0;
  assign reg_addr  = active ? s_addr : cap_addr;
  assign reg_wdata = active ? s_data : cap_data;

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd, reg_wr}));
  p_rd_not_twice_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_rd) |=> !(|reg_rd));
  p_wr_after_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr) |-> $past(req.wr_act));
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq
  import hbi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sep,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] en,
  output logic [NCH-1:0] irq_out,
  output logic [NCH-1:0] irq_oe,
  output logic [NCH-1:0] op2_n
);
  logic any_pend;
  assign any_pend = |pend;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign op2_n[i] = ~en[i];
      if (i == 0) begin : g_shared
        assign irq_oe[i]  = sep ? en[i] : any_pend;
        assign irq_out[i] = sep ? pend[i] : 1'b0;
      end else begin : g_own
        assign irq_oe[i]  = sep & en[i];
        assign irq_out[i] = sep & pend[i];
      end
    end
  endgenerate

  p_od_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sep && irq_oe[0]) |-> (irq_out[0] == 1'b0));
  p_second_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sep |-> !irq_oe[1]);
endmodule

// File: rtl/dsbus_front.sv
module dsbus_front
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style_sep,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] rdata_out,
  output logic              data_oe,
  output logic [1:0]        reg_rd,
  output logic [1:0]        reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata0,
  input  logic [DATA_W-1:0] reg_rdata1,
  input  logic [1:0]        irq_pend,
  input  logic [1:0]        irq_en,
  output logic [1:0]        irq_out,
  output logic [1:0]        irq_oe,
  output logic [1:0]        op2_n
);
  localparam int PW = ADDR_W + DATA_W;

  logic [3:0]    s_pins;
  logic [PW-1:0] s_payload;
  logic          s_sep;
  cyc_req_t      req;
  logic          rd_start, wr_end, rd_live;

  hbi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync_pins (
    .clk(clk), .rst_n(rst_n), .d({rd_n, wr_n, cs0_n, cs1_n}), .q(s_pins));

  hbi_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_payload (
    .clk(clk), .rst_n(rst_n), .d({addr, bus_din}), .q(s_payload));

  hbi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mode (
    .clk(clk), .rst_n(rst_n), .d(style_sep), .q(s_sep));

  assign req = decode_cycle(s_sep, s_pins[3], s_pins[2], s_pins[1], s_pins[0]);

  hbi_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cycle (
    .clk(clk), .rst_n(rst_n), .req(req),
    .s_addr(s_payload[PW-1:DATA_W]), .s_data(s_payload[DATA_W-1:0]),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_live(rd_live), .rd_start(rd_start), .wr_end(wr_end));

  assign data_oe   = rd_live;
  assign rdata_out = req.ch ? reg_rdata1 : reg_rdata0;

  hbi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sep(style_sep), .pend(irq_pend), .en(irq_en),
    .irq_out(irq_out), .irq_oe(irq_oe), .op2_n(op2_n));

  p_phase_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req.rd_act && req.wr_act));
  p_no_drive_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr) |-> !data_oe);
  p_rd_pulse_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> data_oe);
  p_wr_end_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |-> !rd_start);
endmodule

// File: tb/dsbus_front_tb.sv
module dsbus_front_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic style_sep = 1, rd_n = 1, wr_n = 1, cs0_n = 1, cs1_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] bus_din = 0;
  logic [7:0] rdata_out, reg_wdata, reg_rdata0, reg_rdata1;
  logic data_oe;
  logic [1:0] reg_rd, reg_wr, irq_pend = 0, irq_en = 0, irq_out, irq_oe, op2_n;
  logic [2:0] reg_addr;

  int checks = 0, errors = 0;
  int wr_cnt[2], rd_cnt[2];
  logic [2:0] last_waddr, last_raddr;
  logic [7:0] last_wdata;
  logic [7:0] regs0 [8];
  logic [7:0] regs1 [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsbus_front u_dut (
    .clk(clk), .rst_n(rst_n), .style_sep(style_sep), .rd_n(rd_n), .wr_n(wr_n),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr), .bus_din(bus_din),
    .rdata_out(rdata_out), .data_oe(data_oe), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata0(reg_rdata0),
    .reg_rdata1(reg_rdata1), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_out(irq_out), .irq_oe(irq_oe), .op2_n(op2_n));

  // register stub
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin regs0[i] <= 8'h00; regs1[i] <= 8'h00; end
    end else begin
      if (reg_wr[0]) regs0[reg_addr] <= reg_wdata;
      if (reg_wr[1]) regs1[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata0 = regs0[reg_addr];
  assign reg_rdata1 = regs1[reg_addr];

  // pulse monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      wr_cnt[0] <= 0; wr_cnt[1] <= 0; rd_cnt[0] <= 0; rd_cnt[1] <= 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (reg_wr[c]) begin
          wr_cnt[c] <= wr_cnt[c] + 1; last_waddr <= reg_addr; last_wdata <= reg_wdata;
        end
        if (reg_rd[c]) begin
          rd_cnt[c] <= rd_cnt[c] + 1; last_raddr <= reg_addr;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sep_write(input int ch, input logic [2:0] a, input logic [7:0] d);
    int w0 = wr_cnt[ch];
    style_sep = 1; addr = a; bus_din = d;
    if (ch == 0) cs0_n = 0; else cs1_n = 0;
    idle(1); wr_n = 0; idle(4);
    chk(data_oe == 0, "R7 no drive during write", data_oe, 0);
    wr_n = 1; idle(1);
    bus_din = ~d; addr = ~a; cs0_n = 1; cs1_n = 1;
    idle(6);
    chk(wr_cnt[ch] == w0 + 1, "R3 one write pulse", wr_cnt[ch], w0 + 1);
    chk(last_waddr == a && last_wdata == d, "R3 write payload",
        {last_waddr, last_wdata}, {a, d});
  endtask

  task automatic sep_read(input int ch, input logic [2:0] a, input logic [7:0] exp);
    int r0 = rd_cnt[ch];
    int ro = rd_cnt[1-ch];
    style_sep = 1; addr = a;
    if (ch == 0) cs0_n = 0; else cs1_n = 0;
    idle(1); rd_n = 0; idle(5);
    chk(data_oe == 1, "R2 drive during read", data_oe, 1);
    chk(rdata_out == exp, "R7 read data", rdata_out, exp);
    rd_n = 1; idle(1); cs0_n = 1; cs1_n = 1; idle(5);
    chk(data_oe == 0, "R2 drive released", data_oe, 0);
    chk(rd_cnt[ch] == r0 + 1 && last_raddr == a, "R4 R2 one read pulse right channel",
        rd_cnt[ch], r0 + 1);
    chk(rd_cnt[1-ch] == ro, "R4 other channel untouched", rd_cnt[1-ch], ro);
  endtask

  task automatic rw_write(input int ch, input logic [2:0] a, input logic [7:0] d);
    int w0 = wr_cnt[ch];
    style_sep = 0; addr = a; bus_din = d; cs1_n = ch[0]; wr_n = 0;
    idle(1); cs0_n = 0; idle(4);
    chk(data_oe == 0, "R7 no drive in dir-line write", data_oe, 0);
    cs0_n = 1; idle(1); bus_din = ~d; wr_n = 1; idle(6);
    chk(wr_cnt[ch] == w0 + 1, "R5 R6 dir-line write pulse", wr_cnt[ch], w0 + 1);
    chk(last_waddr == a && last_wdata == d, "R5 dir-line payload",
        {last_waddr, last_wdata}, {a, d});
  endtask

  task automatic rw_read(input int ch, input logic [2:0] a, input logic [7:0] exp);
    int r0 = rd_cnt[ch];
    style_sep = 0; addr = a; cs1_n = ch[0]; wr_n = 1;
    idle(1); cs0_n = 0; idle(5);
    chk(data_oe == 1 && rdata_out == exp, "R6 dir-line read data", rdata_out, exp);
    cs0_n = 1; idle(6);
    chk(rd_cnt[ch] == r0 + 1, "R5 dir-line single read", rd_cnt[ch], r0 + 1);
  endtask

  task automatic t_reset;
    chk(data_oe == 0, "R1 no drive after reset", data_oe, 0);
    chk(reg_rd == 0 && reg_wr == 0, "R1 no pulses after reset", {reg_rd, reg_wr}, 0);
    idle(4);
    chk(wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1] == 0, "R1 idle counts",
        wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1], 0);
  endtask

  task automatic t_both_cs;
    int tot = wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1];
    style_sep = 1; cs0_n = 0; cs1_n = 0; idle(1);
    rd_n = 0; idle(5);
    chk(data_oe == 0, "R4 both selects no drive", data_oe, 0);
    rd_n = 1; wr_n = 0; idle(5); wr_n = 1; idle(1);
    cs0_n = 1; cs1_n = 1; idle(1);
    cs0_n = 0; idle(1); rd_n = 0; wr_n = 0; idle(5);
    chk(data_oe == 0, "R4 both strobes no drive", data_oe, 0);
    rd_n = 1; wr_n = 1; idle(1); cs0_n = 1; idle(6);
    chk(wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1] == tot, "R4 illegal no pulse",
        wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1], tot);
  endtask

  task automatic t_rw_rd_ignored;
    int tot = wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1];
    int w0 = wr_cnt[0];
    style_sep = 0; cs1_n = 0; wr_n = 1; idle(2);
    rd_n = 0; idle(5);
    chk(data_oe == 0, "R5 rd_n ignored no drive", data_oe, 0);
    rd_n = 1; idle(6);
    chk(wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1] == tot, "R5 rd_n ignored no pulse",
        wr_cnt[0] + wr_cnt[1] + rd_cnt[0] + rd_cnt[1], tot);
    // rd_n low during a direction-line write must not turn it into a read
    addr = 3'd6; bus_din = 8'h3C; wr_n = 0; rd_n = 0; idle(1); cs0_n = 0; idle(5);
    chk(data_oe == 0, "R5 write despite rd_n low", data_oe, 0);
    cs0_n = 1; idle(1); wr_n = 1; rd_n = 1; idle(6);
    chk(wr_cnt[0] == w0 + 1 && regs0[6] == 8'h3C, "R5 write landed", regs0[6], 8'h3C);
  endtask

  task automatic t_irq;
    for (int m = 0; m < 2; m++) begin
      style_sep = m[0];
      for (int v = 0; v < 16; v++) begin
        irq_pend = v[1:0]; irq_en = v[3:2]; #1;
        if (m == 1) begin
          chk(irq_oe == irq_en && irq_out == irq_pend && op2_n == ~irq_en,
              "R9 per-channel gating", {irq_oe, irq_out, op2_n},
              {irq_en, irq_pend, ~irq_en});
        end else begin
          chk(irq_oe[0] == (|irq_pend) && (!irq_oe[0] || irq_out[0] == 0) && irq_oe[1] == 0,
              "R10 shared open drain", {irq_oe, irq_out}, {1'b0, |irq_pend, 2'b00});
        end
      end
    end
    irq_pend = 0; irq_en = 0;
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    sep_write(0, 3'd1, 8'hA5);
    sep_write(1, 3'd5, 8'h5A);
    sep_write(0, 3'd7, 8'hC3);
    sep_read(0, 3'd1, 8'hA5);
    sep_read(1, 3'd5, 8'h5A);
    sep_read(1, 3'd1, 8'h00);
    sep_read(0, 3'd7, 8'hC3);
    t_both_cs();
    rw_write(1, 3'd2, 8'h96);
    rw_write(0, 3'd2, 8'h69);
    rw_read(1, 3'd2, 8'h96);
    rw_read(0, 3'd2, 8'h69);
    t_rw_rd_ignored();
    t_irq();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule